// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised storage register, eight bits by default, that can hold its contents, shift toward its upper end, shift toward its lower end, or take a parallel word from a shared bus. A two-bit select picks the operation, and the register acts on it at every rising clock edge. The shared bus is split into three signals: an input word, an output word and a single drive enable. A pad ring or a bus fabric joins these into real tri-state lines.

The bus drive enable goes high only when both active-low output controls are low and the select is not asking for a parallel load. In load mode the shared lines are therefore free to carry the incoming word. The output controls only gate the drive enable and never stop the register from working. The two serial outputs always carry the end bits, so several blocks can be chained for longer shifts while the bus is idle. An active-low clear empties the register at once, with no clock needed.

Top module: `usr_shift_bus`

## Requirements
- R1: The select encodes the operation as 00 hold, 01 shift toward the upper end, 10 shift toward the lower end, and 11 parallel load. In hold mode, with clear high, the contents stay unchanged across any number of clock edges, whatever the bus input and serial inputs carry.
- R2: On a rising edge with select 01, bit 0 takes `ser_up_in`, and each bit i above 0 takes the old value of bit i-1.
- R3: On a rising edge with select 10, bit W-1 takes `ser_down_in`, and each bit i below W-1 takes the old value of bit i+1.
- R4: On a rising edge with select 11, the register takes the value on `bus_in`.
- R5: `bus_oe` is high exactly when `oc_a_n` and `oc_b_n` are both low and the select is not 11. It follows these inputs combinationally.
- R6: The output controls have no effect on hold, shift, load or clear.
- R7: While `clr_n` is low, the register reads all zeros. This takes effect immediately when `clr_n` falls, even between clock edges, and the register stays at zero across clock edges in any mode until `clr_n` rises.
- R8: `ser_lo_out` always equals bit 0 and `ser_hi_out` always equals bit W-1, whatever the state of `bus_oe`. Both therefore read low while clear is asserted.
- R9: `bus_out` always shows the current register contents. `bus_oe` alone decides whether that word is driven onto the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Operation select (00 hold, 01 up, 10 down, 11 load) |
| oc_a_n | input | 1 | Output control A, active low |
| oc_b_n | input | 1 | Output control B, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_down_in | input | 1 | Serial bit entering bit W-1 on a downward shift |
| bus_in | input | W | Word sampled from the shared bus in load mode |
| bus_out | output | W | Register contents offered to the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| ser_lo_out | output | 1 | Always-driven copy of bit 0 |
| ser_hi_out | output | 1 | Always-driven copy of bit W-1 |

## Verification
The bench sends patterns with alternating bits through both shift directions, so a design that swaps the neighbours or feeds the wrong serial input shows up as a mismatched word. It toggles the output controls while shifting and loads while they are high; a design that gates register updates on the drive enable would freeze its contents there. It visits all sixteen combinations of select and output controls to catch a drive enable that stays high in load mode. It also drops clear halfway between edges in load mode and holds it over an edge; a synchronous-only clear, or one that lets the load win, leaves a nonzero word.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       oc_a_n,
  input  logic       oc_b_n,
  output usr_mode_e  mode,
  output logic       drive_en
);
  always_comb begin
    mode     = usr_mode_e'(sel);
    // load mode frees the shared lines so they can act as inputs
    drive_en = !oc_a_n && !oc_b_n && (mode != MODE_LOAD);
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      clr_n,
  input  usr_mode_e mode,
  input  logic      from_below,
  input  logic      from_above,
  input  logic      par_in,
  output logic      q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= 1'b0;
    end else begin
      unique case (mode)
        MODE_HOLD: q <= q;
        MODE_UP:   q <= from_below;
        MODE_DOWN: q <= from_above;
        MODE_LOAD: q <= par_in;
      endcase
    end
  end
endmodule

// File: rtl/usr_shift_bus.sv
module usr_shift_bus
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   sel,
  input  logic         oc_a_n,
  input  logic         oc_b_n,
  input  logic         ser_up_in,
  input  logic         ser_down_in,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         ser_lo_out,
  output logic         ser_hi_out
);
  localparam int TOP = W - 1;

  usr_mode_e    mode;
  logic [W-1:0] bits;

  usr_mode_decode u_dec (
    .sel      (sel),
    .oc_a_n   (oc_a_n),
    .oc_b_n   (oc_b_n),
    .mode     (mode),
    .drive_en (bus_oe)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic below, above;
    if (i == 0) begin : g_lo
      assign below = ser_up_in;
    end else begin : g_lo_mid
      assign below = bits[i-1];
    end
    if (i == TOP) begin : g_hi
      assign above = ser_down_in;
    end else begin : g_hi_mid
      assign above = bits[i+1];
    end
    usr_cell u_cell (
      .clk        (clk),
      .clr_n      (clr_n),
      .mode       (mode),
      .from_below (below),
      .from_above (above),
      .par_in     (bus_in[i]),
      .q          (bits[i])
    );
  end

  assign bus_out    = bits;
  assign ser_lo_out = bits[0];
  assign ser_hi_out = bits[TOP];
endmodule

// File: rtl/usr_shift_bus_chk.sv
module usr_shift_bus_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic [1:0]   sel,
  input logic         oc_a_n,
  input logic         oc_b_n,
  input logic         ser_up_in,
  input logic         ser_down_in,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         ser_lo_out,
  input logic         ser_hi_out
);
  // R1
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b00) |=> $stable(bus_out));
  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b01) |=> bus_out == {$past(bus_out[W-2:0]), $past(ser_up_in)});
  // R3
  shift_down_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b10) |=> bus_out == {$past(ser_down_in), $past(bus_out[W-1:1])});
  // R4
  load_takes_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (sel == 2'b11) |=> bus_out == $past(bus_in));
  // R5
  oe_rule_chk: assert property (@(posedge clk)
    bus_oe == (!oc_a_n && !oc_b_n && sel != 2'b11));
  // R7
  clear_zero_chk: assert property (@(posedge clk)
    !clr_n |-> (bus_out == '0));
  // R8
  serial_ends_chk: assert property (@(posedge clk)
    (ser_lo_out == bus_out[0]) && (ser_hi_out == bus_out[W-1]));
endmodule

bind usr_shift_bus usr_shift_bus_chk #(.W(W)) u_chk (.*);

// File: tb/usr_shift_bus_test.sv
`timescale 1ns/1ps
module usr_shift_bus_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic oc_a_n = 1'b0, oc_b_n = 1'b0;
  logic ser_up_in = 1'b0, ser_down_in = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out;
  logic bus_oe, ser_lo_out, ser_hi_out;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] mq = '0;

  typedef struct {
    logic [W-1:0] q;
    logic         oe;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  usr_shift_bus #(.W(W)) uut (.*);

  function automatic logic oe_of(logic [1:0] s, logic a, logic b);
    return !a && !b && (s != 2'b11);
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (bus_out !== e.q || bus_oe !== e.oe ||
        ser_lo_out !== e.q[0] || ser_hi_out !== e.q[W-1]) begin
      fails++;
      $display("FAIL %s: got q=%h oe=%b lo=%b hi=%b, want q=%h oe=%b lo=%b hi=%b",
               e.tag, bus_out, bus_oe, ser_lo_out, ser_hi_out,
               e.q, e.oe, e.q[0], e.q[W-1]);
    end
  endtask

  // driver: drive one cycle of inputs, push the expected post-edge state
  task automatic step(input logic [1:0] s, input logic su, input logic sd,
                      input logic [W-1:0] din, input logic a, input logic b,
                      input string tag);
    exp_t e;
    @(negedge clk);
    sel = s; ser_up_in = su; ser_down_in = sd; bus_in = din;
    oc_a_n = a; oc_b_n = b;
    if (!clr_n) mq = '0;
    else case (s)
      2'b01: mq = {mq[W-2:0], su};
      2'b10: mq = {sd, mq[W-1:1]};
      2'b11: mq = din;
      default: mq = mq;
    endcase
    e.q = mq; e.oe = oe_of(s, a, b); e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compare after each edge has settled
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) compare(sb.pop_front());
  end

  task automatic now_check(input string tag);
    exp_t e;
    e.q = mq; e.oe = oe_of(sel, oc_a_n, oc_b_n); e.tag = tag;
    compare(e);
  endtask

  logic done = 1'b0;
  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat = 8'b0100_1101;
    #1 clr_n = 1'b0;
    #0.5 mq = '0;
    now_check("R7 reset state");
    step(2'b00, 0, 0, '0, 0, 0, "R7 held in reset");
    @(negedge clk); clr_n = 1'b1;

    step(2'b11, 0, 0, 8'hA5, 0, 0, "R4 load A5");
    for (int i = 0; i < 4; i++)
      step(2'b00, i[0], ~i[0], 8'h3C ^ 8'(i), 0, 0, "R1 hold");
    for (int i = 0; i < 8; i++)
      step(2'b01, pat[i], 0, 8'hFF, 0, 0, "R2 shift up");
    for (int i = 0; i < 8; i++)
      step(2'b10, 0, ~pat[i], 8'h00, 0, 0, "R3 shift down");
    for (int i = 0; i < 6; i++)
      step(2'b01, i[1], 0, '0, i[0], i[1], "R6 shift with oc toggling");
    step(2'b11, 0, 0, 8'h5A, 1, 1, "R6 load with outputs off");
    step(2'b00, 0, 0, 8'h00, 1, 0, "R9 hold shows loaded word");
    for (int i = 0; i < 16; i++)
      step(i[3:2], i[0], i[1], 8'h81, i[0], i[1], "R5 oe combos");

    // asynchronous clear between edges, in load mode
    step(2'b11, 0, 0, 8'hFF, 0, 0, "R8 ends high before clear");
    @(negedge clk); #0.5 clr_n = 1'b0;
    #0.5 mq = '0;
    now_check("R7 clear between edges");
    step(2'b11, 0, 0, 8'hFF, 0, 0, "R7 clear beats load");
    step(2'b01, 1, 1, 8'hFF, 0, 0, "R8 ends low during clear");
    @(negedge clk); clr_n = 1'b1;
    for (int i = 0; i < 3; i++)
      step(2'b10, 0, 1, '0, 0, 0, "R3 fill from top after clear");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule